// File: doc/BRIEF.md
# UART Interrupt Status Aggregator

This block keeps the interrupt state of a serial port. Single-cycle event pulses come from the receive path, the transmit data path, the receive-timeout counter, the four modem-status inputs and the four receive error detectors. Each pulse sets its own bit in an 11-bit raw status register. A mask register selects which raw bits may raise an interrupt. The masked status is the raw status ANDed with the mask.

Six registered interrupt lines are driven from the masked status. One combined line covers every status bit. Five group lines cover receive, transmit, receive timeout, modem status and error. A small register port lets software write the mask, read the raw and masked status, and clear raw bits by writing ones to a clear address. Register offsets on that port: 0 is the mask (read/write), 1 is the raw status (read-only), 2 is the masked status (read-only) and 3 is the clear register (write-only, reads as zero).

Top module: `uart_irq_agg`

## Requirements
- R1: After reset, the raw status, the mask and all six interrupt outputs are zero, and every register reads zero.
- R2: Each event pulse sets its own status bit. The bit positions are: ring indicator 0, CTS 1, DCD 2, DSR 3, receive 4, transmit 5, receive timeout 6, framing error 7, parity error 8, break error 9, overrun 10. The modem inputs ms_evt_i[3:0] map to bits 3:0, and the error inputs err_evt_i[3:0] map to bits 10:7.
- R3: Each transmit data write pulse (tx_wr_i) sets status bit 5.
- R4: Reading offset 2 returns the raw status ANDed with the mask. Offset 1 returns the raw status, offset 0 returns the mask, and offset 3 returns zero.
- R5: A write to offset 0 replaces the whole mask with the written value.
- R6: A write to offset 3 clears every raw bit written as one. Raw bits written as zero keep their value.
- R7: When an event pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: The group lines cover these status bits: receive line bit 4, transmit line bit 5, timeout line bit 6, modem line bits 3:0, error line bits 10:7. Each line is high when any masked bit in its group is set.
- R9: The combined line is high when any of the 11 masked bits is set, so it equals the OR of the five group lines.
- R10: The outputs are registered. They change on the clock edge after the edge on which the raw status or the mask changes.
- R11: Writes to offsets 1 and 2 have no effect on the raw status or on the mask.
- R12: An event sets its raw bit even while that bit is masked. The bit then raises its lines once it is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_evt_i | input | 1 | Receive level event pulse |
| tx_wr_i | input | 1 | Transmit data write pulse |
| rt_evt_i | input | 1 | Receive timeout event pulse |
| ms_evt_i | input | 4 | Modem change pulses: DSR, DCD, CTS, ring indicator (bits 3 to 0) |
| err_evt_i | input | 4 | Error pulses: overrun, break, parity, framing (bits 3 to 0) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 11 | Register write data |
| reg_rdata_o | output | 11 | Register read data (combinational from the address) |
| irq_comb_o | output | 1 | Combined interrupt |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_tx_o | output | 1 | Transmit interrupt |
| irq_rt_o | output | 1 | Receive timeout interrupt |
| irq_ms_o | output | 1 | Modem status interrupt |
| irq_err_o | output | 1 | Error interrupt |

## Verification
The assertions check on every cycle that the combined line matches the OR of the group lines. They also check that an event always leaves its bit set, even against a simultaneous clear, and that a clear removes the written bits when no event competes. They further check that the raw status and the mask hold when nothing addresses them, including on writes to the read-only offsets, and that an all-zero mask keeps the combined line low on the next cycle. The bit-to-line mapping, the exact one-cycle output latency after a mask write, and the partial-clear patterns are shown only by the bench's directed scenarios. In those scenarios a model of the status and mask predicts every readback and every line.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int STATUS_W  = 11;
  localparam int ADDR_W    = 2;
  localparam int NUM_LINES = 6;
  localparam int MS_W      = 4;
  localparam int ERR_W     = 4;

  localparam int BIT_RX  = 4;
  localparam int BIT_TX  = 5;
  localparam int BIT_RT  = 6;
  localparam int BIT_ERR = 7;

  localparam logic [ADDR_W-1:0] OFS_MASK   = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_RAW    = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_MASKED = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_CLEAR  = 2'd3;

  typedef enum int {
    LN_COMB = 0, LN_RX = 1, LN_TX = 2, LN_RT = 3, LN_MS = 4, LN_ERR = 5
  } line_e;

  typedef logic [STATUS_W-1:0] status_t;

  function automatic status_t line_group(int idx);
    status_t g;
    g = '0;
    case (idx)
      LN_COMB: g = '1;
      LN_RX:   g[BIT_RX] = 1'b1;
      LN_TX:   g[BIT_TX] = 1'b1;
      LN_RT:   g[BIT_RT] = 1'b1;
      LN_MS:   g[MS_W-1:0] = '1;
      LN_ERR:  g[BIT_ERR +: ERR_W] = '1;
      default: g = '0;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import uart_irq_pkg::*;
#(
  parameter int W = STATUS_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] raw_o
);
  logic [W-1:0] raw_q, raw_d, clr_eff;

  assign clr_eff = clr_en_i ? clr_i : '0;
  // set has priority over clear on the same bit
  assign raw_d   = (raw_q & ~clr_eff) | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= raw_d;
  end

  assign raw_o = raw_q;

  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((raw_q & $past(set_i)) == $past(set_i)));
  // R6
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((raw_q & $past(clr_i & ~set_i)) == '0));
  // R2
  raw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && !clr_en_i) |=> $stable(raw_q));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import uart_irq_pkg::*;
#(
  parameter int W = STATUS_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_en_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

  // R5
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mask_q));
  // R5
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (mask_q == $past(wdata_i)));
endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv
  import uart_irq_pkg::*;
#(
  parameter int      W     = STATUS_W,
  parameter status_t GROUP = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] masked_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(masked_i & GROUP[W-1:0]);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/uart_irq_agg.sv
module uart_irq_agg
  import uart_irq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_evt_i,
  input  logic                tx_wr_i,
  input  logic                rt_evt_i,
  input  logic [MS_W-1:0]     ms_evt_i,
  input  logic [ERR_W-1:0]    err_evt_i,
  input  logic                reg_wr_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [STATUS_W-1:0] reg_wdata_i,
  output logic [STATUS_W-1:0] reg_rdata_o,
  output logic                irq_comb_o,
  output logic                irq_rx_o,
  output logic                irq_tx_o,
  output logic                irq_rt_o,
  output logic                irq_ms_o,
  output logic                irq_err_o
);
  status_t set_vec, raw, mask, masked;
  logic    mask_wr, clr_wr;
  logic [NUM_LINES-1:0] irq_vec;

  assign set_vec = {err_evt_i, rt_evt_i, tx_wr_i, rx_evt_i, ms_evt_i};
  assign mask_wr = reg_wr_i && (reg_addr_i == OFS_MASK);
  assign clr_wr  = reg_wr_i && (reg_addr_i == OFS_CLEAR);

  irq_status_reg #(.W(STATUS_W)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clr_en_i (clr_wr),
    .clr_i    (reg_wdata_i),
    .raw_o    (raw)
  );

  irq_mask_reg #(.W(STATUS_W)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (mask_wr),
    .wdata_i (reg_wdata_i),
    .mask_o  (mask)
  );

  assign masked = raw & mask;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irq_line_drv #(.W(STATUS_W), .GROUP(line_group(g))) u_drv (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .masked_i (masked),
      .irq_o    (irq_vec[g])
    );
  end

  always_comb begin
    unique case (reg_addr_i)
      OFS_MASK:   reg_rdata_o = mask;
      OFS_RAW:    reg_rdata_o = raw;
      OFS_MASKED: reg_rdata_o = masked;
      default:    reg_rdata_o = '0;
    endcase
  end

  assign irq_comb_o = irq_vec[LN_COMB];
  assign irq_rx_o   = irq_vec[LN_RX];
  assign irq_tx_o   = irq_vec[LN_TX];
  assign irq_rt_o   = irq_vec[LN_RT];
  assign irq_ms_o   = irq_vec[LN_MS];
  assign irq_err_o  = irq_vec[LN_ERR];

  // R9
  comb_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_comb_o == (irq_rx_o | irq_tx_o | irq_rt_o | irq_ms_o | irq_err_o));
  // R11
  ro_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && (reg_addr_i == OFS_RAW || reg_addr_i == OFS_MASKED)
     && set_vec == '0) |=> ($stable(raw) && $stable(mask)));
  // R10
  zero_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |=> !irq_comb_o);
  // R3
  tx_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_i |=> raw[BIT_TX]);
endmodule

// File: tb/sim_uart_irq_agg.sv
`timescale 1ns/1ps
module sim_uart_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_evt = 0, tx_wr = 0, rt_evt = 0;
  logic [3:0]  ms_evt = '0, err_evt = '0;
  logic        reg_wr = 0;
  logic [1:0]  reg_addr = '0;
  logic [10:0] reg_wdata = '0;
  logic [10:0] reg_rdata;
  logic irq_comb, irq_rx, irq_tx, irq_rt, irq_ms, irq_err;

  int checks = 0;
  int errors = 0;
  logic [10:0] exp_raw = '0;
  logic [10:0] exp_mask = '0;

  always #5 clk = ~clk;

  uart_irq_agg u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_evt_i(rx_evt), .tx_wr_i(tx_wr), .rt_evt_i(rt_evt),
    .ms_evt_i(ms_evt), .err_evt_i(err_evt),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .irq_comb_o(irq_comb), .irq_rx_o(irq_rx), .irq_tx_o(irq_tx),
    .irq_rt_o(irq_rt), .irq_ms_o(irq_ms), .irq_err_o(irq_err)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_lines(input logic [10:0] m);
    // {err, ms, rt, tx, rx, comb}
    return {|m[10:7], |m[3:0], m[6], m[5], m[4], |m};
  endfunction

  // read offset in the low phase; rdata is combinational
  task automatic rd(input logic [1:0] a, output logic [10:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic check_regs(input string req);
    logic [10:0] d;
    rd(2'd0, d); chk(d, exp_mask, {req, " mask"});
    rd(2'd1, d); chk(d, exp_raw, {req, " raw"});
    rd(2'd2, d); chk(d, exp_raw & exp_mask, {req, " masked"});
    rd(2'd3, d); chk(d, 0, {req, " clear reads zero"});
  endtask

  task automatic check_lines(input string req);
    chk({irq_err, irq_ms, irq_rt, irq_tx, irq_rx, irq_comb},
        exp_lines(exp_raw & exp_mask), req);
  endtask

  // registers updated at the edge just passed; lines settle one edge later
  task automatic settle_and_check(input string req);
    check_regs(req);
    @(negedge clk);
    check_lines({req, " lines"});
  endtask

  task automatic wr(input logic [1:0] a, input logic [10:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (a == 2'd0) exp_mask = d;
    else if (a == 2'd3) exp_raw = exp_raw & ~d;
  endtask

  task automatic evt(input logic [10:0] v);
    @(negedge clk);
    {err_evt, rt_evt, tx_wr, rx_evt, ms_evt} = v;
    @(negedge clk);
    {err_evt, rt_evt, tx_wr, rx_evt, ms_evt} = '0;
    exp_raw = exp_raw | v;
  endtask

  task automatic t_reset;
    check_regs("R1");
    chk({irq_err, irq_ms, irq_rt, irq_tx, irq_rx, irq_comb}, 0, "R1 lines");
  endtask

  task automatic t_bitmap;
    wr(2'd0, 11'h7FF);
    for (int b = 0; b < 11; b++) begin
      evt(11'(1) << b);
      settle_and_check($sformatf("R2 R8 R9 bit %0d", b));
      wr(2'd3, 11'h7FF);
      settle_and_check("R6 clear all");
    end
  endtask

  task automatic t_tx;
    @(negedge clk); tx_wr = 1;
    @(negedge clk); tx_wr = 0; exp_raw[5] = 1'b1;
    settle_and_check("R3");
    chk(irq_tx, 1, "R3 tx line");
    wr(2'd3, 11'h020);
    settle_and_check("R3 cleared");
  endtask

  task automatic t_mask_latency;
    wr(2'd0, 11'h000);
    evt(11'h481);
    settle_and_check("R12 masked events set raw");
    chk(irq_comb, 0, "R12 comb low");
    // mask write: the line must still be low one cycle after the write edge
    @(negedge clk);
    reg_wr = 1; reg_addr = 2'd0; reg_wdata = 11'h400;
    @(negedge clk);
    reg_wr = 0; exp_mask = 11'h400;
    chk(irq_err, 0, "R10 err not yet");
    @(negedge clk);
    chk(irq_err, 1, "R10 err after one cycle");
    chk(irq_ms, 0, "R8 ms masked");
    settle_and_check("R5 R4");
    wr(2'd0, 11'h00F);
    settle_and_check("R5 mask replaced");
    chk(irq_err, 0, "R5 err dropped");
  endtask

  task automatic t_partial_clear;
    wr(2'd0, 11'h7FF);
    evt(11'h7FF);
    settle_and_check("R6 all set");
    wr(2'd3, 11'h0F0);
    settle_and_check("R6 partial clear");
    wr(2'd3, 11'h000);
    settle_and_check("R6 zero clear");
    wr(2'd3, 11'h70F);
    settle_and_check("R6 rest cleared");
  endtask

  task automatic t_set_wins;
    evt(11'h050);
    @(negedge clk);
    reg_wr = 1; reg_addr = 2'd3; reg_wdata = 11'h050; rx_evt = 1;
    @(negedge clk);
    reg_wr = 0; rx_evt = 0;
    exp_raw = (exp_raw & ~11'h050) | 11'h010;
    settle_and_check("R7 set beats clear");
    chk(irq_rx, 1, "R7 rx line");
    chk(irq_rt, 0, "R7 rt cleared");
    wr(2'd3, 11'h7FF);
  endtask

  task automatic t_ro_writes;
    evt(11'h300);
    wr(2'd0, 11'h3F0);
    wr(2'd1, 11'h000);
    wr(2'd2, 11'h7FF);
    settle_and_check("R11 read-only offsets");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_bitmap;
    t_tx;
    t_mask_latency;
    t_partial_clear;
    t_set_wins;
    t_ro_writes;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule